// File: doc/BRIEF.md
# Channel-Scan Acquisition and Interrupt Controller

This block sits between a host-side register bus and an analog-to-digital converter front end. It steps a channel multiplexer through a programmable, consecutive range of channels, one channel per conversion. Each conversion is started by one of four trigger sources. Each finished result is pushed into a 16-entry sample FIFO. A selectable FIFO condition raises a conversion interrupt. A second, external interrupt input and an external-trigger event are latched beside it, and each latch is cleared by writing a one to it.

Software programs the scan range, the trigger source, the interrupt condition and the block length through a small word-wide register port. It then either starts conversions by writing to the sample address or lets an external edge or pacer tick start them. Samples are drained by reading the sample address. The converter itself lies outside the block. It is driven through a start/done handshake: the block presents a start pulse with a channel number, and the converter later returns a done pulse with the result.

Top module: `scan_acq_ctrl`

Register offsets (`addr`): 0 = sample data, 1 = scan range, 2 = status / clear, 3 = control, 4 = mode, 5 = block length.

## Requirements
- R1: The scan register (offset 1) holds the first channel in bits [5:0] and the last channel in bits [13:8]. After it is written, conversions visit first, first+1, ... up to last and then wrap back to first. Equal fields give one fixed channel. Each conversion result enters the FIFO in order.
- R2: When the first channel is greater than the last channel, every conversion uses the first channel.
- R3: Control bits [1:0] choose the trigger: 0 = software, 1 = falling edge of `ext_trig`, 2 = rising edge of `ext_trig`, 3 = a `pacer_tick` pulse. Events from unselected sources start nothing. A trigger that arrives while a conversion is outstanding is dropped.
- R4: With the software source selected, a write of any value to offset 0 starts exactly one conversion.
- R5: A read of offset 0 returns the oldest FIFO entry and removes it. A read while the FIFO is empty returns the last value removed and leaves the FIFO unchanged.
- R6: Status (offset 2) read bits: 0 = FIFO not empty, 1 = at least 8 entries, 2 = full (16 entries), 3 = external interrupt pending, 4 = conversion interrupt pending, 5 = external trigger seen. Bits 15:6 read 0.
- R7: A result that arrives while the FIFO is full is discarded. The stored entries and the full flag are kept.
- R8: Mode bits [3:2] (offset 4) choose the conversion-interrupt condition: 0 = never, 1 = FIFO not empty, 2 = at least 8 entries, 3 = end of block. For modes 1 and 2 the latch is set on every cycle the condition holds.
- R9: In end-of-block mode the latch is set when the number of completed conversions reaches the block length (offset 5, reset value 4). The count then restarts.
- R10: A write to offset 2 clears the conversion latch with bit 0, the external-trigger latch with bit 1 and the external-interrupt latch with bit 2. Any combination may be cleared in one write. A set in the same cycle wins.
- R11: `irq` is high only when control bit 7 is set and either the conversion latch is set, or control bit 3 is set and the external-interrupt latch is set. A rising edge of `ext_irq_in` sets the external-interrupt latch.
- R12: After reset the FIFO is empty, all latches are clear, `irq` is low, the scan range is channel 0 only, the software trigger is selected, and the mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (pops the FIFO at offset 0) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| ext_trig | input | 1 | External trigger line |
| pacer_tick | input | 1 | One-cycle pacer pulse |
| ext_irq_in | input | 1 | External interrupt request line |
| conv_start | output | 1 | One-cycle converter start pulse |
| conv_chan | output | 6 | Channel for the conversion being started |
| conv_done | input | 1 | Converter result valid pulse |
| conv_data | input | 16 | Converter result |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives scans whose last channel is below the first. A design that counted upward anyway would tag results with channels outside the range. It also drives scans that end at channel 63, where a design that missed the wrap would roll over to channel 0. The FIFO is filled past 16 entries. A design that overwrote entries or wrapped its pointer would return late serial numbers or clear the full flag. Empty reads are repeated, which catches a read pointer that moves on an empty FIFO. Each trigger source is paired with stimulus from the other sources and with back-to-back triggers, so a decoder that listened to the wrong source or restarted a busy converter would produce extra samples. The interrupt tests step through each mode, the block count, the gate and enable bits and combined clears.

// File: rtl/scan_acq_pkg.sv
package scan_acq_pkg;

  localparam int ADDR_W = 3;

  // register offsets
  typedef enum logic [ADDR_W-1:0] {
    A_DATA = 3'd0,
    A_SCAN = 3'd1,
    A_STAT = 3'd2,
    A_CTRL = 3'd3,
    A_MODE = 3'd4,
    A_BLK  = 3'd5
  } addr_e;

  typedef enum logic [1:0] {
    TRG_SOFT = 2'd0,
    TRG_FALL = 2'd1,
    TRG_RISE = 2'd2,
    TRG_PACE = 2'd3
  } trig_e;

  typedef enum logic [1:0] {
    IRQ_POLL   = 2'd0,
    IRQ_NEMPTY = 2'd1,
    IRQ_HALF   = 2'd2,
    IRQ_BLOCK  = 2'd3
  } irqm_e;

  // status bit positions
  localparam int ST_NE    = 0;
  localparam int ST_HALF  = 1;
  localparam int ST_FULL  = 2;
  localparam int ST_XINT  = 3;
  localparam int ST_CONV  = 4;
  localparam int ST_XTRIG = 5;

  // clear bit positions on a status write
  localparam int CL_CONV  = 0;
  localparam int CL_XTRIG = 1;
  localparam int CL_XINT  = 2;

  // control bit positions
  localparam int CT_XEN  = 3;
  localparam int CT_GATE = 7;

  // scan field offsets
  localparam int SC_HI_POS = 8;

endpackage

// File: rtl/sac_trig_sel.sv
module sac_trig_sel
  import scan_acq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  trig_e src,
  input  logic  soft_wr,
  input  logic  ext_trig,
  input  logic  pacer_tick,
  output logic  fire,
  output logic  ext_edge
);

  logic ext_q;
  logic rise_ev;
  logic fall_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_trig;
  end

  assign rise_ev = ext_trig & ~ext_q;
  assign fall_ev = ~ext_trig & ext_q;

  always_comb begin
    unique case (src)
      TRG_SOFT: fire = soft_wr;
      TRG_FALL: fire = fall_ev;
      TRG_RISE: fire = rise_ev;
      TRG_PACE: fire = pacer_tick;
      default:  fire = 1'b0;
    endcase
  end

  assign ext_edge = ((src == TRG_FALL) & fall_ev) | ((src == TRG_RISE) & rise_ev);

  // R3
  edge_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge |-> fire);

  // R3
  soft_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && src != TRG_PACE && !ext_edge) |-> (src == TRG_SOFT && soft_wr));

endmodule

// File: rtl/sac_scan_seq.sv
module sac_scan_seq #(
  parameter int CH_W   = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              load,
  input  logic [CH_W-1:0]   lo,
  input  logic [CH_W-1:0]   hi,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              conv_start_o,
  output logic [CH_W-1:0]   conv_chan_o,
  output logic              busy_o,
  output logic              sample_vld_o,
  output logic [DATA_W-1:0] sample_o
);

  logic [CH_W-1:0] cur;

  // channel that follows cur inside [lo, hi]; inverted or stray cur returns lo
  function automatic logic [CH_W-1:0] next_chan(
    input logic [CH_W-1:0] c,
    input logic [CH_W-1:0] l,
    input logic [CH_W-1:0] h
  );
    if (l > h || c >= h || c < l) return l;
    return c + CH_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur          <= '0;
      busy_o       <= 1'b0;
      conv_start_o <= 1'b0;
      conv_chan_o  <= '0;
      sample_vld_o <= 1'b0;
      sample_o     <= '0;
    end else begin
      conv_start_o <= 1'b0;
      sample_vld_o <= 1'b0;
      if (fire && !busy_o) begin
        conv_start_o <= 1'b1;
        conv_chan_o  <= cur;
        busy_o       <= 1'b1;
      end
      if (busy_o && conv_done_i) begin
        busy_o       <= 1'b0;
        sample_vld_o <= 1'b1;
        sample_o     <= conv_data_i;
        cur          <= next_chan(cur, lo, hi);
      end
      if (load) cur <= lo;
    end
  end

  // R3
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && busy_o) |=> !conv_start_o);

  // R2
  inverted_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start_o && lo > hi && $stable(lo) && $stable(hi) && !$past(load) && !load)
      |-> conv_chan_o == lo);

  // R1
  done_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld_o |-> $past(busy_o));

endmodule

// File: rtl/sac_sample_fifo.sv
module sac_sample_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              not_empty,
  output logic              half,
  output logic              full
);

  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(DEPTH / 2);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr;
  logic [AW-1:0]     rptr;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] last_q;
  logic              do_push;
  logic              do_pop;

  assign full      = (cnt == DEPTH_C);
  assign not_empty = (cnt != '0);
  assign half      = (cnt >= HALF_C);
  assign do_push   = push_req & ~full;
  assign do_pop    = pop_req & not_empty;
  assign rd_data   = not_empty ? mem[rptr] : last_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
      last_q <= '0;
    end else begin
      if (do_push) wptr <= wptr + AW'(1);
      if (do_pop) begin
        rptr   <= rptr + AW'(1);
        last_q <= mem[rptr];
      end
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_req) |=> (full && $stable(wptr)));

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !not_empty) |=> $stable(rptr));

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= DEPTH_C);

endmodule

// File: rtl/sac_irq_ctrl.sv
module sac_irq_ctrl
  import scan_acq_pkg::*;
#(
  parameter int BLK_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  irqm_e            mode,
  input  logic             gate,
  input  logic             xint_en,
  input  logic [2:0]       clr,
  input  logic             fifo_ne,
  input  logic             fifo_half,
  input  logic             sample_done,
  input  logic             ext_edge,
  input  logic             ext_irq_in,
  input  logic [BLK_W-1:0] blk_len,
  output logic             conv_pend,
  output logic             xtrig_pend,
  output logic             xint_pend,
  output logic             irq_o
);

  logic [BLK_W-1:0] blk_cnt;
  logic             blk_hit;
  logic             conv_set;
  logic             xi_q;
  logic             xint_rise;

  // end of block: this completion brings the count up to the length
  function automatic logic block_done(
    input logic [BLK_W-1:0] count,
    input logic [BLK_W-1:0] len
  );
    return (count + BLK_W'(1)) >= len;
  endfunction

  assign blk_hit   = (mode == IRQ_BLOCK) & sample_done & block_done(blk_cnt, blk_len);
  assign xint_rise = ext_irq_in & ~xi_q;

  always_comb begin
    unique case (mode)
      IRQ_NEMPTY: conv_set = fifo_ne;
      IRQ_HALF:   conv_set = fifo_half;
      IRQ_BLOCK:  conv_set = blk_hit;
      default:    conv_set = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_cnt    <= '0;
      conv_pend  <= 1'b0;
      xtrig_pend <= 1'b0;
      xint_pend  <= 1'b0;
      xi_q       <= 1'b0;
    end else begin
      xi_q <= ext_irq_in;
      if (mode != IRQ_BLOCK)  blk_cnt <= '0;
      else if (blk_hit)       blk_cnt <= '0;
      else if (sample_done)   blk_cnt <= blk_cnt + BLK_W'(1);
      conv_pend  <= conv_set  | (conv_pend  & ~clr[CL_CONV]);
      xtrig_pend <= ext_edge  | (xtrig_pend & ~clr[CL_XTRIG]);
      xint_pend  <= xint_rise | (xint_pend  & ~clr[CL_XINT]);
    end
  end

  assign irq_o = gate & (conv_pend | (xint_en & xint_pend));

  // R8
  polled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[CL_CONV] && mode == IRQ_POLL) |=> !conv_pend);

  // R10
  xint_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[CL_XINT] && !xint_rise) |=> !xint_pend);

  // R11
  xint_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xint_rise |=> xint_pend);

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (conv_pend || xint_pend));

endmodule

// File: rtl/scan_acq_ctrl.sv
module scan_acq_ctrl
  import scan_acq_pkg::*;
#(
  parameter int CH_W       = 6,
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int BLK_W      = 16,
  parameter int BLK_RST    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ext_trig,
  input  logic              pacer_tick,
  input  logic              ext_irq_in,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              irq
);

  logic [CH_W-1:0]   scan_lo;
  logic [CH_W-1:0]   scan_hi;
  trig_e             trig_src;
  logic              xint_en;
  logic              gate;
  irqm_e             irq_mode;
  logic [BLK_W-1:0]  blk_len;
  logic              scan_load;

  logic              soft_wr;
  logic              pop;
  logic [2:0]        clr;
  logic              fire;
  logic              ext_edge;
  logic              busy;
  logic              sample_vld;
  logic [DATA_W-1:0] sample;
  logic [DATA_W-1:0] fifo_q;
  logic              fifo_ne;
  logic              fifo_half;
  logic              fifo_full;
  logic              conv_pend;
  logic              xtrig_pend;
  logic              xint_pend;

  assign soft_wr = wr_en & (addr == A_DATA);
  assign pop     = rd_en & (addr == A_DATA);
  assign clr     = (wr_en && addr == A_STAT) ? wdata[2:0] : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_lo   <= '0;
      scan_hi   <= '0;
      trig_src  <= TRG_SOFT;
      xint_en   <= 1'b0;
      gate      <= 1'b0;
      irq_mode  <= IRQ_POLL;
      blk_len   <= BLK_W'(BLK_RST);
      scan_load <= 1'b0;
    end else begin
      scan_load <= wr_en & (addr == A_SCAN);
      if (wr_en) begin
        unique case (addr)
          A_SCAN: begin
            scan_lo <= wdata[CH_W-1:0];
            scan_hi <= wdata[SC_HI_POS+CH_W-1:SC_HI_POS];
          end
          A_CTRL: begin
            trig_src <= trig_e'(wdata[1:0]);
            xint_en  <= wdata[CT_XEN];
            gate     <= wdata[CT_GATE];
          end
          A_MODE: irq_mode <= irqm_e'(wdata[3:2]);
          A_BLK:  blk_len  <= wdata[BLK_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_DATA: rdata = fifo_q;
      A_SCAN: begin
        rdata[CH_W-1:0]                   = scan_lo;
        rdata[SC_HI_POS+CH_W-1:SC_HI_POS] = scan_hi;
      end
      A_STAT: begin
        rdata[ST_NE]    = fifo_ne;
        rdata[ST_HALF]  = fifo_half;
        rdata[ST_FULL]  = fifo_full;
        rdata[ST_XINT]  = xint_pend;
        rdata[ST_CONV]  = conv_pend;
        rdata[ST_XTRIG] = xtrig_pend;
      end
      A_CTRL: begin
        rdata[1:0]     = trig_src;
        rdata[CT_XEN]  = xint_en;
        rdata[CT_GATE] = gate;
      end
      A_MODE: rdata[3:2] = irq_mode;
      A_BLK:  rdata[BLK_W-1:0] = blk_len;
      default: rdata = '0;
    endcase
  end

  sac_trig_sel u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .src        (trig_src),
    .soft_wr    (soft_wr),
    .ext_trig   (ext_trig),
    .pacer_tick (pacer_tick),
    .fire       (fire),
    .ext_edge   (ext_edge)
  );

  sac_scan_seq #(.CH_W(CH_W), .DATA_W(DATA_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire         (fire),
    .load         (scan_load),
    .lo           (scan_lo),
    .hi           (scan_hi),
    .conv_done_i  (conv_done),
    .conv_data_i  (conv_data),
    .conv_start_o (conv_start),
    .conv_chan_o  (conv_chan),
    .busy_o       (busy),
    .sample_vld_o (sample_vld),
    .sample_o     (sample)
  );

  sac_sample_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (sample_vld),
    .push_data (sample),
    .pop_req   (pop),
    .rd_data   (fifo_q),
    .not_empty (fifo_ne),
    .half      (fifo_half),
    .full      (fifo_full)
  );

  sac_irq_ctrl #(.BLK_W(BLK_W)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (irq_mode),
    .gate        (gate),
    .xint_en     (xint_en),
    .clr         (clr),
    .fifo_ne     (fifo_ne),
    .fifo_half   (fifo_half),
    .sample_done (sample_vld),
    .ext_edge    (ext_edge),
    .ext_irq_in  (ext_irq_in),
    .blk_len     (blk_len),
    .conv_pend   (conv_pend),
    .xtrig_pend  (xtrig_pend),
    .xint_pend   (xint_pend),
    .irq_o       (irq)
  );

  // R3
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !$past(busy));

  // R12
  gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |-> !irq);

endmodule

// File: tb/scan_acq_ctrl_tb.sv
module scan_acq_ctrl_tb;

  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ext_trig = 1'b0;
  logic        pacer_tick = 1'b0;
  logic        ext_irq_in = 1'b0;
  logic        conv_start;
  logic [5:0]  conv_chan;
  logic        conv_done;
  logic [15:0] conv_data;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;
  logic [7:0] exp_serial = '0;

  always #10 clk = ~clk;

  scan_acq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .ext_trig(ext_trig), .pacer_tick(pacer_tick),
    .ext_irq_in(ext_irq_in), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_data(conv_data), .irq(irq)
  );

  // converter stub: fixed latency, result = {2'b0, channel, serial}
  int         lat_cnt;
  logic [5:0] st_chan;
  logic [7:0] serial;
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (!rst_n) begin
      lat_cnt <= 0; serial <= '0; st_chan <= '0; conv_data <= '0;
    end else if (conv_start) begin
      lat_cnt <= LAT; st_chan <= conv_chan;
    end else if (lat_cnt == 1) begin
      conv_done <= 1'b1;
      conv_data <= {2'b00, st_chan, serial};
      serial    <= serial + 8'd1;
      lat_cnt   <= 0;
    end else if (lat_cnt > 1) begin
      lat_cnt <= lat_cnt - 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #2 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic soft_conv();
    bus_wr(3'd0, 16'h5A5A);
    settle();
    exp_serial++;
  endtask

  function automatic logic [5:0] mdl_next(input logic [5:0] c, input logic [5:0] l, input logic [5:0] h);
    if (h < l) return l;
    if (c == h) return l;
    return c + 6'd1;
  endfunction

  // each entry: {first channel, last channel, conversions}
  localparam logic [17:0] VEC [6] = '{
    {6'd0,  6'd3,  6'd6},
    {6'd5,  6'd5,  6'd3},
    {6'd10, 6'd7,  6'd4},
    {6'd60, 6'd63, 6'd9},
    {6'd2,  6'd4,  6'd7},
    {6'd0,  6'd0,  6'd1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rv;
    logic [15:0] last;
    logic [5:0]  ch;
    logic [7:0]  s0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    bus_rd(3'd2, rv); chk("R12 status", rv, 16'h0000);
    chk("R12 irq", irq, 1'b0);
    bus_rd(3'd1, rv); chk("R12 scan", rv, 16'h0000);
    bus_rd(3'd3, rv); chk("R12 ctrl", rv, 16'h0000);
    bus_rd(3'd5, rv); chk("R9 block reset", rv, 16'd4);
    bus_rd(3'd0, rv); chk("R12 data", rv, 16'h0000);

    // vector table: scan ranges, software triggers, FIFO order
    for (int v = 0; v < 6; v++) begin
      logic [5:0] lo, hi, n;
      {lo, hi, n} = VEC[v];
      bus_wr(3'd1, {2'b00, hi, 2'b00, lo});
      repeat (3) @(negedge clk);
      s0 = exp_serial;
      for (int k = 0; k < int'(n); k++) soft_conv();
      ch = lo;
      for (int k = 0; k < int'(n); k++) begin
        bus_rd(3'd0, rv);
        chk((lo > hi) ? "R2 inverted scan" : "R1 scan order", rv,
            {2'b00, ch, s0 + 8'(k)});
        ch = mdl_next(ch, lo, hi);
      end
      bus_rd(3'd2, rv);
      chk("R4 one conversion per write", rv[0], 1'b0);
    end

    // R5 empty read returns last value, pointer stays
    last = {2'b00, 6'd0, exp_serial - 8'd1};
    bus_rd(3'd0, rv); chk("R5 empty read", rv, last);
    bus_rd(3'd0, rv); chk("R5 empty read again", rv, last);
    bus_wr(3'd1, 16'h0505); repeat (3) @(negedge clk);
    soft_conv();
    bus_rd(3'd0, rv); chk("R5 after empty read", rv, {2'b00, 6'd5, exp_serial - 8'd1});

    // R6 / R7 fill levels and overflow
    s0 = exp_serial;
    for (int k = 0; k < 7; k++) soft_conv();
    bus_rd(3'd2, rv); chk("R6 seven entries", rv, 16'h0001);
    soft_conv();
    bus_rd(3'd2, rv); chk("R6 half at eight", rv, 16'h0003);
    for (int k = 0; k < 10; k++) soft_conv();
    bus_rd(3'd2, rv); chk("R7 full kept", rv, 16'h0007);
    for (int k = 0; k < 16; k++) begin
      bus_rd(3'd0, rv);
      chk("R7 stored entries", rv, {2'b00, 6'd5, s0 + 8'(k)});
    end
    bus_rd(3'd2, rv); chk("R7 drained", rv, 16'h0000);

    // R3 busy drop: back-to-back software writes
    s0 = exp_serial;
    bus_wr(3'd0, 16'h0001);
    bus_wr(3'd0, 16'h0002);
    settle(); exp_serial++;
    bus_rd(3'd0, rv); chk("R3 busy trigger dropped", rv, {2'b00, 6'd5, s0});
    bus_rd(3'd2, rv); chk("R3 busy single sample", rv[0], 1'b0);

    // R8 mode 1 with gate
    bus_wr(3'd3, 16'h0080);
    bus_wr(3'd4, 16'h0004);
    soft_conv();
    chk("R8 not-empty irq", irq, 1'b1);
    bus_rd(3'd2, rv); chk("R8 conv pending", rv, 16'h0011);
    bus_rd(3'd0, rv);
    bus_wr(3'd2, 16'h0001);
    @(negedge clk);
    chk("R10 conv cleared", irq, 1'b0);

    // R8 polled mode never raises
    bus_wr(3'd4, 16'h0000);
    soft_conv();
    chk("R8 polled no irq", irq, 1'b0);
    bus_rd(3'd2, rv); chk("R8 polled status", rv, 16'h0001);
    bus_rd(3'd0, rv);

    // R8 half-full mode
    bus_wr(3'd4, 16'h0008);
    for (int k = 0; k < 7; k++) soft_conv();
    chk("R8 half not yet", irq, 1'b0);
    soft_conv();
    chk("R8 half raised", irq, 1'b1);
    for (int k = 0; k < 8; k++) bus_rd(3'd0, rv);
    bus_wr(3'd2, 16'h0001); @(negedge clk);
    chk("R10 half cleared", irq, 1'b0);

    // R9 end of block, length 3
    bus_wr(3'd5, 16'd3);
    bus_wr(3'd4, 16'h000C);
    soft_conv(); soft_conv();
    chk("R9 block not reached", irq, 1'b0);
    soft_conv();
    chk("R9 block reached", irq, 1'b1);
    for (int k = 0; k < 3; k++) bus_rd(3'd0, rv);
    bus_wr(3'd2, 16'h0001); @(negedge clk);
    chk("R9 block cleared", irq, 1'b0);

    // R11 gate off masks irq but latch sets
    bus_wr(3'd3, 16'h0000);
    bus_wr(3'd4, 16'h0004);
    soft_conv();
    chk("R11 gate off", irq, 1'b0);
    bus_rd(3'd2, rv); chk("R11 latch without gate", rv[4], 1'b1);
    bus_rd(3'd0, rv);
    bus_wr(3'd2, 16'h0001);
    bus_wr(3'd4, 16'h0000);

    // R3 rising-edge source; software write ignored
    bus_wr(3'd3, 16'h0002);
    bus_wr(3'd0, 16'h0000); settle();
    bus_rd(3'd2, rv); chk("R3 soft ignored in rise mode", rv, 16'h0000);
    s0 = exp_serial;
    @(negedge clk); ext_trig = 1'b1; repeat (3) @(negedge clk);
    ext_trig = 1'b0; settle(); exp_serial++;
    bus_rd(3'd2, rv); chk("R3 rise trig seen", rv, 16'h0021);
    bus_rd(3'd0, rv); chk("R3 rise sample", rv, {2'b00, 6'd5, s0});
    bus_rd(3'd2, rv); chk("R3 falling edge ignored", rv[0], 1'b0);
    bus_wr(3'd2, 16'h0002);
    bus_rd(3'd2, rv); chk("R10 xtrig cleared", rv, 16'h0000);

    // R3 falling-edge source
    bus_wr(3'd3, 16'h0001);
    @(negedge clk); ext_trig = 1'b1; settle();
    bus_rd(3'd2, rv); chk("R3 rise ignored in fall mode", rv, 16'h0000);
    ext_trig = 1'b0; settle(); exp_serial++;
    bus_rd(3'd2, rv); chk("R3 fall trig", rv, 16'h0021);
    bus_rd(3'd0, rv);
    bus_wr(3'd2, 16'h0002);

    // R3 pacer source; external edges ignored
    bus_wr(3'd3, 16'h0003);
    @(negedge clk); ext_trig = 1'b1; repeat (2) @(negedge clk); ext_trig = 1'b0; settle();
    bus_rd(3'd2, rv); chk("R3 ext ignored in pacer mode", rv, 16'h0000);
    @(negedge clk); pacer_tick = 1'b1; @(negedge clk); pacer_tick = 1'b0; settle(); exp_serial++;
    bus_rd(3'd0, rv); chk("R3 pacer sample", rv, {2'b00, 6'd5, exp_serial - 8'd1});

    // R11 external interrupt with and without its enable
    bus_wr(3'd3, 16'h0080);
    @(negedge clk); ext_irq_in = 1'b1; repeat (2) @(negedge clk);
    bus_rd(3'd2, rv); chk("R11 xint latched", rv, 16'h0008);
    chk("R11 xint not enabled", irq, 1'b0);
    bus_wr(3'd3, 16'h0088); @(negedge clk);
    chk("R11 xint enabled", irq, 1'b1);
    ext_irq_in = 1'b0;
    bus_wr(3'd2, 16'h0004); @(negedge clk);
    chk("R10 xint cleared", irq, 1'b0);

    // R10 combined clear of all three latches
    bus_wr(3'd5, 16'd1);
    bus_wr(3'd4, 16'h000C);
    bus_wr(3'd3, 16'h0002);
    @(negedge clk); ext_trig = 1'b1; ext_irq_in = 1'b1; settle();
    ext_trig = 1'b0; ext_irq_in = 1'b0; exp_serial++;
    bus_rd(3'd2, rv); chk("R10 all latched", rv, 16'h0039);
    bus_rd(3'd0, rv);
    bus_wr(3'd2, 16'h0007);
    bus_rd(3'd2, rv); chk("R10 combined clear", rv, 16'h0000);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule